// File: doc/BRIEF.md
# Firmware Image Loader

This engine takes a firmware image that sits in a word-addressed buffer and turns it into a stream of memory write commands for a processing engine, but only after it has checked the whole image. It reads a three-word header (marker, identity, payload length) through a read port with one cycle of latency. The marker may appear in either byte order. When it appears reversed, the engine swaps the bytes of every later word before using it. It then checks the declared length against the byte count it was given, the engine number and device class held in the identity word, and whether the target engine is already running.

The payload begins with a table of two-word entries. Each entry holds a kind and a payload offset, and the table ends at an end marker. The engine finds the end marker first. It then makes a validation pass over every entry: it checks the kind, checks that the offset points past the table and inside the payload, and checks that the code block at that offset (target address, length, data) fits both inside the image and inside the target memory. Only when every entry has passed does a second pass issue the write commands. A one-cycle `done` pulse then reports success or a 3-bit failure code.

Top module: `fw_image_loader`

## Requirements
- R1: Image word 0 must equal 0xFEEDF00D (native order) or 0x0DF0EDFE (reversed order). In reversed order, every image word from index 1 onward is byte-swapped before use, so write data equals the swapped value. Any other marker ends the load with code 1.
- R2: The load ends with code 2 unless (payload length in words × 4 + 12) equals `img_len_bytes`. The payload length is image word 2 and the payload begins at image word 3.
- R3: Bits 27:24 of the identity word (image word 1) must equal `engine_id`. When `small_variant` is high, bits 31:28 must be zero. Either violation ends the load with code 3.
- R4: If the header checks pass while `engine_running` is high, the load ends with code 7.
- R5: The table is scanned at even payload indices 0, 2, 4, … for the value 0xF. If the scan index reaches the payload length first, the load ends with code 4. A marker at index 0 means there are no entries, and the load succeeds with no writes.
- R6: An entry kind other than 0 (instruction) or 1 (data) ends the load with code 5. An offset below 2×entries+1, or above length−2, also ends it with code 5.
- R7: A code block with target+length greater than the memory size ends the load with code 6. When `small_variant` is high, instruction memory holds 0x1000 words for engine 0 and 0x800 words for other engines, and data memory holds 0x800 words. When it is low, both memories hold 0x1000 words. A block whose offset+2+length exceeds the payload length also ends the load with code 6.
- R8: Each data word k of a block is issued, in entry order, with `mem_cmd` 0x11 (instruction) or 0x13 (data), at address target+k.
- R9: When any failure is reported, no write command has been issued during that load.
- R10: `done` is high for exactly one cycle per load. `err_code` is 0 on success and keeps its value until the next accepted start. A `start` pulse while `busy` is high is ignored.
- R11: A block of length zero issues no writes, and the blocks after it are still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load when idle |
| small_variant | input | 1 | Selects the small memory map and the device-class check |
| engine_id | input | 4 | Number of the target engine |
| engine_running | input | 1 | Target engine is executing; a load is refused |
| img_len_bytes | input | 32 | Total image length in bytes |
| img_rd_en | output | 1 | Image read request |
| img_rd_addr | output | AW | Image word index |
| img_rd_data | input | 32 | Image word, valid the cycle after the request |
| mem_wr_valid | output | 1 | A write command is present this cycle |
| mem_cmd | output | 8 | Write command code, 0x11 or 0x13 |
| mem_addr | output | MAW | Target word address |
| mem_wdata | output | 32 | Normalised data word |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| err_code | output | 3 | Result of the last load, 0 = success |

## Verification
On every cycle, the assertions check the legality of write command codes, that every write address lies below the selected memory size, that `done` lasts a single cycle, that the engine is quiet while idle, and that no failed load has written anything. Which code each malformed image produces, the byte-order normalisation of data, the exact address and data sequence, the acceptance exactly at a memory limit, and the ignoring of a second start can only be shown by the bench's built images. The bench sweeps both byte orders, all small engine numbers, device classes and every failure kind.

// File: rtl/fw_image_loader.sv
module fw_image_loader #(
  parameter int AW         = 16,
  parameter int MAW        = 16,
  parameter int MEM_LARGE  = 4096,
  parameter int MEM_SMALL  = 2048
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           small_variant,
  input  logic [3:0]     engine_id,
  input  logic           engine_running,
  input  logic [31:0]    img_len_bytes,
  output logic           img_rd_en,
  output logic [AW-1:0]  img_rd_addr,
  input  logic [31:0]    img_rd_data,
  output logic           mem_wr_valid,
  output logic [7:0]     mem_cmd,
  output logic [MAW-1:0] mem_addr,
  output logic [31:0]    mem_wdata,
  output logic           busy,
  output logic           done,
  output logic [2:0]     err_code
);

  localparam logic [31:0] MARK     = 32'hFEEDF00D;
  localparam logic [31:0] MARK_REV = 32'h0DF0EDFE;
  localparam logic [32:0] SZ_L     = 33'(MEM_LARGE);
  localparam logic [32:0] SZ_S     = 33'(MEM_SMALL);

  typedef enum logic [3:0] {
    S_IDLE, S_MAGIC, S_ID, S_SIZE, S_SCAN, S_DTYPE,
    S_DOFF, S_TADDR, S_TLEN, S_COPY, S_NEXT
  } st_t;

  st_t         st;
  logic        rv, swap, phase, typ_q, done_q;
  logic [2:0]  err_q;
  logic [7:0]  idh;
  logic [31:0] size_q, idx, nblk, off_q, taddr_q, len_q, j_q;
  logic [AW-1:0] raddr;

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  wire [31:0] w         = swap ? bswap(img_rd_data) : img_rd_data;
  wire [33:0] hdr_bytes = {w, 2'b00} + 34'd12;
  wire        scan_over = {idx, 1'b0} >= {1'b0, size_q};
  wire [32:0] tbl_end   = {nblk, 1'b0} + 33'd1;
  wire        bad_off   = ({1'b0, w} < tbl_end) || ({1'b0, w} + 33'd2 > {1'b0, size_q});
  wire [32:0] imem_sz   = (small_variant && engine_id != 4'd0) ? SZ_S : SZ_L;
  wire [32:0] dmem_sz   = small_variant ? SZ_S : SZ_L;
  wire [32:0] cur_sz    = typ_q ? dmem_sz : imem_sz;
  wire        over_mem  = ({1'b0, taddr_q} + {1'b0, w}) > cur_sz;
  wire        over_img  = ({2'b00, off_q} + 34'd2 + {2'b00, w}) > {2'b00, size_q};
  wire        last_blk  = (idx + 32'd1) == nblk;

  always_comb begin
    case (st)
      S_ID:    raddr = AW'(1);
      S_SIZE:  raddr = AW'(2);
      S_SCAN,
      S_DTYPE: raddr = AW'(32'd3 + {idx[30:0], 1'b0});
      S_DOFF:  raddr = AW'(32'd4 + {idx[30:0], 1'b0});
      S_TADDR: raddr = AW'(32'd3 + off_q);
      S_TLEN:  raddr = AW'(32'd4 + off_q);
      S_COPY:  raddr = AW'(32'd5 + off_q + j_q);
      default: raddr = '0;
    endcase
  end

  assign busy         = st != S_IDLE;
  assign img_rd_en    = busy && st != S_NEXT && !rv && !(st == S_SCAN && scan_over);
  assign img_rd_addr  = raddr;
  assign mem_wr_valid = st == S_COPY && rv;
  assign mem_cmd      = typ_q ? 8'h13 : 8'h11;
  assign mem_addr     = MAW'(taddr_q + j_q);
  assign mem_wdata    = w;
  assign done         = done_q;
  assign err_code     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  rv <= 1'b0;  swap <= 1'b0;  phase <= 1'b0;
      typ_q <= 1'b0; done_q <= 1'b0; err_q <= 3'd0; idh <= 8'd0;
      size_q <= '0;  idx <= '0;   nblk <= '0;    off_q <= '0;
      taddr_q <= '0; len_q <= '0; j_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            st <= S_MAGIC; rv <= 1'b0; swap <= 1'b0;
            phase <= 1'b0; idx <= '0; err_q <= 3'd0;
          end
        S_NEXT:
          if (last_blk) begin
            if (!phase) begin
              phase <= 1'b1; idx <= '0; st <= S_DTYPE;
            end else begin
              st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd0;
            end
          end else begin
            idx <= idx + 32'd1; st <= S_DTYPE;
          end
        default:
          if (!rv) begin
            if (st == S_SCAN && scan_over) begin
              st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd4;
            end else begin
              rv <= 1'b1;
            end
          end else begin
            rv <= 1'b0;
            case (st)
              S_MAGIC:
                if (img_rd_data == MARK) st <= S_ID;
                else if (img_rd_data == MARK_REV) begin
                  swap <= 1'b1; st <= S_ID;
                end else begin
                  st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd1;
                end
              S_ID: begin
                idh <= w[31:24]; st <= S_SIZE;
              end
              S_SIZE: begin
                size_q <= w;
                if (hdr_bytes != {2'b00, img_len_bytes}) begin
                  st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd2;
                end else if (idh[3:0] != engine_id ||
                             (small_variant && idh[7:4] != 4'd0)) begin
                  st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd3;
                end else if (engine_running) begin
                  st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd7;
                end else begin
                  idx <= '0; st <= S_SCAN;
                end
              end
              S_SCAN:
                if (w == 32'hF) begin
                  nblk <= idx; idx <= '0;
                  if (idx == '0) begin
                    st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd0;
                  end else st <= S_DTYPE;
                end else idx <= idx + 32'd1;
              S_DTYPE:
                if (w == 32'd0 || w == 32'd1) begin
                  typ_q <= w[0]; st <= S_DOFF;
                end else begin
                  st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd5;
                end
              S_DOFF:
                if (bad_off) begin
                  st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd5;
                end else begin
                  off_q <= w; st <= S_TADDR;
                end
              S_TADDR: begin
                taddr_q <= w; st <= S_TLEN;
              end
              S_TLEN: begin
                len_q <= w;
                if (over_mem || over_img) begin
                  st <= S_IDLE; done_q <= 1'b1; err_q <= 3'd6;
                end else if (phase && w != 32'd0) begin
                  j_q <= '0; st <= S_COPY;
                end else st <= S_NEXT;
              end
              S_COPY:
                if (j_q + 32'd1 == len_q) st <= S_NEXT;
                else j_q <= j_q + 32'd1;
              default: st <= S_IDLE;
            endcase
          end
      endcase
    end
  end

endmodule

// File: rtl/fw_image_loader_chk.sv
module fw_image_loader_chk #(
  parameter int MAW       = 16,
  parameter int MEM_LARGE = 4096,
  parameter int MEM_SMALL = 2048
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2:0]     err_code,
  input logic           mem_wr_valid,
  input logic [7:0]     mem_cmd,
  input logic [MAW-1:0] mem_addr,
  input logic           small_variant,
  input logic [3:0]     engine_id,
  input logic           img_rd_en
);

  logic wrote;
  always_ff @(posedge clk) begin
    if (!rst_n) wrote <= 1'b0;
    else if (start && !busy) wrote <= 1'b0;
    else if (mem_wr_valid) wrote <= 1'b1;
  end

  wire [32:0] lim_i = (small_variant && engine_id != 4'd0) ? 33'(MEM_SMALL) : 33'(MEM_LARGE);
  wire [32:0] lim_d = small_variant ? 33'(MEM_SMALL) : 33'(MEM_LARGE);

  AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_cmd == 8'h11 || mem_cmd == 8'h13)); // R8
  AST_IMEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_cmd == 8'h11) |-> (33'(mem_addr) < lim_i)); // R7
  AST_DMEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_cmd == 8'h13) |-> (33'(mem_addr) < lim_d)); // R7
  AST_NO_WRITE_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != 3'd0) |-> !wrote); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_wr_valid && !img_rd_en)); // R10
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !$past(done) && !$past(start)) |-> $stable(err_code)); // R10

endmodule

bind fw_image_loader fw_image_loader_chk #(.MAW(MAW), .MEM_LARGE(MEM_LARGE), .MEM_SMALL(MEM_SMALL)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_code(err_code), .mem_wr_valid(mem_wr_valid), .mem_cmd(mem_cmd),
  .mem_addr(mem_addr), .small_variant(small_variant), .engine_id(engine_id),
  .img_rd_en(img_rd_en)
);

// File: tb/fw_image_loader_tb_top.sv
module fw_image_loader_tb_top;
  localparam int AW = 16;
  localparam int MAW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic small_variant = 1'b0, engine_running = 1'b0;
  logic [3:0] engine_id = 4'd0;
  logic [31:0] img_len_bytes = '0;
  logic img_rd_en, mem_wr_valid, busy, done;
  logic [AW-1:0] img_rd_addr;
  logic [31:0] img_rd_data = '0, mem_wdata;
  logic [7:0] mem_cmd;
  logic [MAW-1:0] mem_addr;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  fw_image_loader #(.AW(AW), .MAW(MAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .small_variant(small_variant),
    .engine_id(engine_id), .engine_running(engine_running),
    .img_len_bytes(img_len_bytes), .img_rd_en(img_rd_en),
    .img_rd_addr(img_rd_addr), .img_rd_data(img_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_cmd(mem_cmd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .err_code(err_code));

  logic [31:0] img [0:63];
  always @(posedge clk)
    if (img_rd_en) img_rd_data <= (img_rd_addr < 64) ? img[img_rd_addr[5:0]] : 32'd0;

  int checks = 0, fails = 0, cap_n = 0, n_done = 0;
  logic [2:0] last_err = '0;
  logic [7:0] cap_cmd [0:63];
  logic [31:0] cap_addr [0:63];
  logic [31:0] cap_data [0:63];

  always @(negedge clk) if (rst_n) begin
    if (mem_wr_valid && cap_n < 64) begin
      cap_cmd[cap_n] = mem_cmd; cap_addr[cap_n] = 32'(mem_addr);
      cap_data[cap_n] = mem_wdata; cap_n++;
    end
    if (done) begin n_done++; last_err = err_code; end
  end

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  bit g_sw;
  logic [31:0] g_t0, g_a0, g_l0, g_t1, g_a1, g_l1, g_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [31:0] v);
    img[i] = g_sw ? bswap(v) : v;
  endtask
  task automatic pl(input int j, input logic [31:0] v);
    put(3 + j, v);
  endtask

  task automatic mk(input bit sw, input logic [3:0] dev, input logic [3:0] eng,
                    input logic [31:0] t0, a0, l0, t1, a1, l1);
    g_sw = sw; g_t0 = t0; g_a0 = a0; g_l0 = l0; g_t1 = t1; g_a1 = a1; g_l1 = l1;
    g_n = 9 + l0 + l1;
    for (int i = 0; i < 64; i++) img[i] = '0;
    img[0] = sw ? 32'h0DF0EDFE : 32'hFEEDF00D;
    put(1, {dev, eng, 24'h000102});
    put(2, g_n);
    pl(0, t0); pl(1, 5); pl(2, t1); pl(3, 7 + l0); pl(4, 32'hF);
    pl(5, a0); pl(6, l0);
    for (int k = 0; k < int'(l0); k++) pl(7 + k, 32'h1234_0000 + k);
    pl(7 + int'(l0), a1); pl(8 + int'(l0), l1);
    for (int k = 0; k < int'(l1); k++) pl(9 + int'(l0) + k, 32'h5678_0000 + k);
    img_len_bytes = g_n * 4 + 12;
  endtask

  task automatic run(input bit poke);
    cap_n = 0; n_done = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 3000 && n_done == 0; c++) begin
      @(negedge clk);
      if (poke && c == 4) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_result(input string req, input logic [2:0] code);
    chk(n_done == 1, req, "done pulses", n_done, 1);
    chk(last_err == code, req, "err_code", 32'(last_err), 32'(code));
    if (code != 0) chk(cap_n == 0, "R9", "writes after failure", cap_n, 0);
    else begin
      chk(cap_n == int'(g_l0 + g_l1), "R8", "write count", cap_n, g_l0 + g_l1);
      for (int k = 0; k < cap_n && k < int'(g_l0 + g_l1); k++) begin
        bit b1 = k >= int'(g_l0);
        logic [31:0] kk = b1 ? 32'(k) - g_l0 : 32'(k);
        logic [7:0] ec = (b1 ? g_t1[0] : g_t0[0]) ? 8'h13 : 8'h11;
        logic [31:0] ea = (b1 ? g_a1 : g_a0) + kk;
        logic [31:0] ed = (b1 ? 32'h5678_0000 : 32'h1234_0000) + kk;
        chk(cap_cmd[k] == ec, "R8", "cmd", 32'(cap_cmd[k]), 32'(ec));
        chk(cap_addr[k] == ea, "R8", "addr", cap_addr[k], ea);
        chk(cap_data[k] == ed, "R1", "data order", cap_data[k], ed);
      end
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && err_code == 0 && !mem_wr_valid && !img_rd_en,
        "R10", "reset state", {busy, done, err_code, mem_wr_valid, img_rd_en}, 0);

    for (int sw = 0; sw < 2; sw++)
      for (int e = 0; e < 4; e++) begin
        small_variant = 1'b0;
        mk(sw[0], 4'd0, 4'(e), 0, 32'h10 + e, 4, 1, 32'h20, 3);
        engine_id = 4'(e); run(0); expect_result("R1", 0);
        engine_id = 4'(e ^ 1); run(0); expect_result("R3", 3);
      end
    engine_id = 4'd2;
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 4; d++) begin
        small_variant = s[0];
        mk(1'b0, 4'(d), 4'd2, 0, 32'h40, 2, 1, 32'h50, 2);
        run(0); expect_result("R3", (s == 1 && d != 0) ? 3'd3 : 3'd0);
      end
    small_variant = 1'b0;

    begin
      logic [31:0] bad [4] = '{32'h0, 32'hFEEDF00C, 32'h0DF0EDFF, 32'hFFFFFFFF};
      for (int b = 0; b < 4; b++) begin
        mk(1'b0, 0, 2, 0, 0, 2, 1, 8, 2); img[0] = bad[b];
        run(0); expect_result("R1", 1);
      end
    end

    mk(1'b1, 0, 2, 0, 0, 2, 1, 8, 2); img_len_bytes += 4; run(0); expect_result("R2", 2);
    mk(1'b0, 0, 2, 0, 0, 2, 1, 8, 2); img_len_bytes -= 4; run(0); expect_result("R2", 2);
    mk(1'b0, 0, 2, 0, 0, 2, 1, 8, 2); img_len_bytes += 1; run(0); expect_result("R2", 2);

    mk(1'b0, 0, 2, 0, 0, 2, 1, 8, 2); engine_running = 1'b1; run(0); expect_result("R4", 7);
    engine_running = 1'b0;

    mk(1'b0, 0, 2, 0, 32'h20, 4, 1, 32'h20, 3); pl(4, 0); run(0); expect_result("R5", 4);
    mk(1'b0, 0, 2, 0, 0, 2, 1, 8, 2); pl(0, 32'hF); g_l0 = 0; g_l1 = 0;
    run(0); expect_result("R5", 0);

    mk(1'b0, 0, 2, 0, 0, 2, 2, 8, 2); run(0); expect_result("R6", 5);
    mk(1'b1, 0, 2, 0, 0, 2, 32'hE, 8, 2); run(0); expect_result("R6", 5);
    mk(1'b0, 0, 2, 0, 0, 2, 1, 8, 2); pl(3, 4); run(0); expect_result("R6", 5);
    mk(1'b0, 0, 2, 0, 0, 2, 1, 8, 2); pl(1, g_n - 1); run(0); expect_result("R6", 5);

    mk(1'b0, 0, 2, 0, 0, 2, 1, 8, 2); pl(8 + 2, 3); run(0); expect_result("R7", 6);
    small_variant = 1'b1; engine_id = 4'd1;
    mk(1'b0, 0, 1, 0, 32'h800 - 4, 4, 1, 32'h800 - 3, 3); run(0); expect_result("R7", 0);
    mk(1'b0, 0, 1, 0, 32'h800 - 3, 4, 1, 32'h10, 3); run(0); expect_result("R7", 6);
    mk(1'b0, 0, 1, 0, 32'h10, 4, 1, 32'h800 - 2, 3); run(0); expect_result("R7", 6);
    engine_id = 4'd0;
    mk(1'b0, 0, 0, 0, 32'h1000 - 4, 4, 1, 32'h10, 3); run(0); expect_result("R7", 0);
    small_variant = 1'b0; engine_id = 4'd2;
    mk(1'b0, 0, 2, 1, 32'h1000 - 4, 4, 0, 32'h1000 - 3, 3); run(0); expect_result("R7", 0);
    mk(1'b0, 0, 2, 1, 32'h1000 - 3, 4, 0, 32'h10, 3); run(0); expect_result("R7", 6);

    mk(1'b1, 0, 2, 0, 32'h30, 0, 1, 32'h60, 3); run(0); expect_result("R11", 0);

    mk(1'b0, 0, 2, 0, 32'h30, 6, 1, 32'h60, 5); run(1); expect_result("R10", 0);
    mk(1'b0, 0, 2, 0, 0, 2, 3, 8, 2); run(0);
    repeat (5) @(negedge clk);
    chk(err_code == 3'd5 && !busy, "R10", "code held after done", 32'(err_code), 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule